// File: doc/BRIEF.md
# Edge Trigger with Capture Alignment

This block sits beside the sample path of a multi-channel logic capture engine. Each accepted sample carries the level of every channel. Once armed, the block watches one configured channel for a configured transition. The transition can be rising, falling or either. When the transition appears, the block records the zero-based position of that sample in the stream since arming. Downstream storage uses this index to place the trigger point inside the captured record.

The block can be told to wait only a bounded number of samples. If nothing matches within that many samples, it gives up and declares a free-running capture, so a capture never waits forever on a trigger that will not come. A limit of zero turns this fallback off. The trigger and fallback outcomes are both final: only a fresh arm pulse starts a new search.

Configuration is taken at the arm pulse and held until the next one. Software can therefore rewrite the configuration inputs at any time without disturbing a search that is in progress.

Top module: `edge_trig_align`

## Requirements
- R1: After reset, and while never armed, `trig_hit`, `free_run`, `cap_active` and `trig_idx` are all 0. Samples presented in this state cause no trigger and no fallback.
- R2: An `arm` pulse clears `trig_hit`, `free_run`, `cap_active` and `trig_idx` on the next cycle and starts a new search. It captures `cfg_chan`, `cfg_edge` and `cfg_timeout`. Changes to those inputs while a search runs have no effect on that search.
- R3: The first valid sample after arming only records the watched channel's level. It never fires a trigger, whatever the level held from earlier runs.
- R4: Edge encoding `cfg_edge`: 0 means rising (previous 0, current 1). 1 means falling (previous 1, current 0). 2 and 3 mean either transition. A transition of the other kind does not fire in modes 0 and 1.
- R5: Only bit `cfg_chan` of `smp_data` is watched. Activity on any other channel never fires.
- R6: Transitions are judged between consecutive samples with `smp_vld` high. Cycles with `smp_vld` low are skipped, whatever `smp_data` shows.
- R7: On a matching sample, `trig_hit` and `cap_active` go high on the following cycle. `trig_idx` takes the number of valid samples accepted since arming before that sample, so the first sample after arming has index 0.
- R8: With `cfg_timeout` = T > 0, if T valid samples pass without a match, `free_run` and `cap_active` go high after the T-th sample and `trig_idx` stays 0. A match on the T-th sample itself wins over the fallback.
- R9: With `cfg_timeout` = 0, the fallback never happens, however many samples arrive.
- R10: After a trigger or fallback, the outputs and `trig_idx` hold their values through any further samples and edges until the next `arm`.
- R11: The sample index saturates at 2^IDX_W - 1. A trigger after that many samples reports the saturated value.
- R12: A sample presented in the same cycle as `arm` is discarded. The next valid sample is treated as the first of the new search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Sample strobe |
| smp_data | input | CH_N | Levels of all channels for this sample |
| cfg_chan | input | SEL_W | Channel to watch, captured at arm |
| cfg_edge | input | 2 | Transition kind, captured at arm |
| cfg_timeout | input | TO_W | Samples to wait before fallback, 0 = forever |
| arm | input | 1 | Start a new search |
| trig_hit | output | 1 | Search ended on a matching transition |
| trig_idx | output | IDX_W | Index of the triggering sample since arm |
| free_run | output | 1 | Search ended by timeout fallback |
| cap_active | output | 1 | Capture running (trigger or fallback) |

## Verification
The bench sweeps every channel, every edge mode and several trigger positions. On the non-watched channels it toggles a pattern every sample, so a design that decoded the wrong bit would fire in the "either" mode. A design that compared the first sample after arming against a stale level would fire at index 0. A design that counted clock cycles instead of valid samples would report an inflated index once the strobe has gaps. The bench also checks the timeout boundary, where a design that is off by one would fall back a sample early, or let the fallback win over a trigger on the last sample. It further drives more samples than the index width can hold, to catch a wrapping index, and arms while a sample is valid, to catch a design that uses that sample as the seed.

// File: rtl/trig_align_pkg.sv
package trig_align_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ARMED = 2'd1,
      ST_TRIG  = 2'd2,
      ST_FREE  = 2'd3
   } trig_state_e;

   localparam logic [1:0] EDGE_RISE = 2'd0;
   localparam logic [1:0] EDGE_FALL = 2'd1;
   localparam int EDGE_ANY_BIT = 1;

endpackage

// File: rtl/trig_edge_det.sv
module trig_edge_det
   import trig_align_pkg::*;
#(
   parameter int CH_N  = 8,
   parameter int SEL_W = $clog2(CH_N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic [CH_N-1:0]  smp,
   input  logic [SEL_W-1:0] sel,
   input  logic [1:0]       mode,
   output logic             seeded,
   output logic             fire
);

   logic prev_q;
   logic seed_q;
   logic cur;
   logic rise;
   logic fall;

   assign cur  = smp[sel];
   assign rise = seed_q & ~prev_q &  cur;
   assign fall = seed_q &  prev_q & ~cur;

   always_comb begin
      if (mode[EDGE_ANY_BIT])
         fire = en & (rise | fall);
      else if (mode == EDGE_FALL)
         fire = en & fall;
      else
         fire = en & rise;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         seed_q <= 1'b0;
      end else if (clr) begin
         seed_q <= 1'b0;
      end else if (en) begin
         prev_q <= cur;
         seed_q <= 1'b1;
      end
   end

   assign seeded = seed_q;

   // R3: a search restarts unseeded
   p_clr_unseeds_r3: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !seed_q);

   // R6: an accepted sample always leaves the detector seeded
   p_seed_after_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !clr) |=> seed_q);

endmodule

// File: rtl/trig_idx_ctr.sv
module trig_idx_ctr #(
   parameter int IDX_W = 16,
   parameter bit SAT   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [IDX_W-1:0] cnt
);

   localparam logic [IDX_W-1:0] CNT_MAX = '1;
   localparam logic [IDX_W-1:0] CNT_ONE = IDX_W'(1);

   logic [IDX_W-1:0] cnt_q;

   generate
      if (SAT) begin : g_sat
         always_ff @(posedge clk) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (clr)
               cnt_q <= '0;
            else if (inc && (cnt_q != CNT_MAX))
               cnt_q <= cnt_q + CNT_ONE;
         end

         // R11: the index holds at its ceiling
         p_sat_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (inc && !clr && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
      end else begin : g_wrap
         always_ff @(posedge clk) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (clr)
               cnt_q <= '0;
            else if (inc)
               cnt_q <= cnt_q + CNT_ONE;
         end
      end
   endgenerate

   assign cnt = cnt_q;

   // R2: arming restarts the count
   p_ctr_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0));

   // R6: no count moves without a valid sample
   p_ctr_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/trig_fsm.sv
module trig_fsm
   import trig_align_pkg::*;
#(
   parameter int TO_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            arm,
   input  logic            smp_vld,
   input  logic            fire,
   input  logic [TO_W-1:0] to_lim,
   output trig_state_e     st
);

   localparam logic [TO_W-1:0] TO_ONE = TO_W'(1);

   trig_state_e     st_q;
   logic [TO_W-1:0] wait_q;
   logic            expire;

   assign expire = (to_lim != '0) &&
                   (({1'b0, wait_q} + {1'b0, TO_ONE}) == {1'b0, to_lim});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         wait_q <= '0;
      end else if (arm) begin
         st_q   <= ST_ARMED;
         wait_q <= '0;
      end else if (st_q == ST_ARMED && smp_vld) begin
         wait_q <= wait_q + TO_ONE;
         if (fire)
            st_q <= ST_TRIG;
         else if (expire)
            st_q <= ST_FREE;
      end
   end

   assign st = st_q;

   // R1: nothing leaves idle without an arm pulse
   p_idle_stays_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE && !arm) |=> (st_q == ST_IDLE));

   // R2: arm always starts a search
   p_arm_waits_r2: assert property (@(posedge clk) disable iff (!rst_n)
      arm |=> (st_q == ST_ARMED));

   // R9: a zero limit never falls back
   p_zero_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_ARMED && to_lim == '0 && !arm) |=> (st_q != ST_FREE));

   // R10: end states are sticky
   p_end_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == ST_TRIG || st_q == ST_FREE) && !arm) |=> $stable(st_q));

endmodule

// File: rtl/edge_trig_align.sv
module edge_trig_align
   import trig_align_pkg::*;
#(
   parameter int  CH_N    = 8,
   parameter int  IDX_W   = 16,
   parameter int  TO_W    = 16,
   parameter bit  IDX_SAT = 1'b1,
   localparam int SEL_W   = $clog2(CH_N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smp_vld,
   input  logic [CH_N-1:0]  smp_data,
   input  logic [SEL_W-1:0] cfg_chan,
   input  logic [1:0]       cfg_edge,
   input  logic [TO_W-1:0]  cfg_timeout,
   input  logic             arm,
   output logic             trig_hit,
   output logic [IDX_W-1:0] trig_idx,
   output logic             free_run,
   output logic             cap_active
);

   initial begin
      a_ch_pow2: assert (CH_N >= 2 && (CH_N & (CH_N - 1)) == 0);
      a_widths:  assert (IDX_W >= 2 && TO_W >= 1);
   end

   logic [SEL_W-1:0] chan_q;
   logic [1:0]       mode_q;
   logic [TO_W-1:0]  to_q;
   logic [IDX_W-1:0] idx_q;
   logic [IDX_W-1:0] cnt;
   trig_state_e      st;
   logic             det_en;
   logic             fire;
   logic             seeded;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chan_q <= '0;
         mode_q <= EDGE_RISE;
         to_q   <= '0;
      end else if (arm) begin
         chan_q <= cfg_chan;
         mode_q <= cfg_edge;
         to_q   <= cfg_timeout;
      end
   end

   assign det_en = smp_vld & ~arm & (st == ST_ARMED);

   trig_edge_det #(.CH_N(CH_N), .SEL_W(SEL_W)) u_det (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (arm),
      .en     (det_en),
      .smp    (smp_data),
      .sel    (chan_q),
      .mode   (mode_q),
      .seeded (seeded),
      .fire   (fire)
   );

   trig_idx_ctr #(.IDX_W(IDX_W), .SAT(IDX_SAT)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (arm),
      .inc   (smp_vld & (st != ST_IDLE)),
      .cnt   (cnt)
   );

   trig_fsm #(.TO_W(TO_W)) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .arm     (arm),
      .smp_vld (smp_vld),
      .fire    (fire),
      .to_lim  (to_q),
      .st      (st)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         idx_q <= '0;
      else if (arm)
         idx_q <= '0;
      else if (fire)
         idx_q <= cnt;
   end

   assign trig_hit   = (st == ST_TRIG);
   assign free_run   = (st == ST_FREE);
   assign cap_active = trig_hit | free_run;
   assign trig_idx   = idx_q;

   // R3: the seeding sample cannot trigger
   p_seed_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_ARMED && smp_vld && !arm && !seeded) |=> !trig_hit);

   // R2: arm wipes the recorded index
   p_arm_idx_r2: assert property (@(posedge clk) disable iff (!rst_n)
      arm |=> (trig_idx == '0 && !cap_active));

   // R10: the recorded index is frozen after a trigger
   p_idx_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_hit && !arm) |=> $stable(trig_idx));

   // R8: fallback and trigger exclude each other
   p_one_outcome_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(trig_hit && free_run));

endmodule

// File: tb/edge_trig_align_bench.sv
module edge_trig_align_bench;

   localparam int CLK_PERIOD = 10;
   localparam int CH_N  = 8;
   localparam int IDX_W = 6;
   localparam int TO_W  = 6;
   localparam int SEL_W = $clog2(CH_N);
   localparam int IDX_MAX = (1 << IDX_W) - 1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             smp_vld = 1'b0;
   logic [CH_N-1:0]  smp_data = '0;
   logic [SEL_W-1:0] cfg_chan = '0;
   logic [1:0]       cfg_edge = '0;
   logic [TO_W-1:0]  cfg_timeout = '0;
   logic             arm = 1'b0;
   logic             trig_hit;
   logic [IDX_W-1:0] trig_idx;
   logic             free_run;
   logic             cap_active;

   int n_chk  = 0;
   int n_fail = 0;
   int cycles = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   edge_trig_align #(.CH_N(CH_N), .IDX_W(IDX_W), .TO_W(TO_W)) u_edge_trig_align (
      .clk         (clk),
      .rst_n       (rst_n),
      .smp_vld     (smp_vld),
      .smp_data    (smp_data),
      .cfg_chan    (cfg_chan),
      .cfg_edge    (cfg_edge),
      .cfg_timeout (cfg_timeout),
      .arm         (arm),
      .trig_hit    (trig_hit),
      .trig_idx    (trig_idx),
      .free_run    (free_run),
      .cap_active  (cap_active)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic chk_state(input string req, input int hit, input int fr, input int idx);
      chk({req, " trig_hit"}, int'(trig_hit), hit);
      chk({req, " free_run"}, int'(free_run), fr);
      chk({req, " cap_active"}, int'(cap_active), (hit | fr));
      chk({req, " trig_idx"}, int'(trig_idx), idx);
   endtask

   task automatic do_arm(input int ch, input int md, input int to);
      @(negedge clk);
      cfg_chan    = SEL_W'(ch);
      cfg_edge    = 2'(md);
      cfg_timeout = TO_W'(to);
      arm = 1'b1;
      @(negedge clk);
      arm = 1'b0;
   endtask

   task automatic send(input logic [CH_N-1:0] d);
      @(negedge clk);
      smp_vld  = 1'b1;
      smp_data = d;
      @(negedge clk);
      smp_vld  = 1'b0;
      smp_data = ~d;
   endtask

   function automatic logic [CH_N-1:0] mk(input int ch, input int lvl, input int k);
      logic [CH_N-1:0] bg;
      bg = (k % 2 == 1) ? '1 : '0;
      bg[ch] = lvl[0];
      return bg;
   endfunction

   initial begin : watchdog
      while (cycles < 100000) begin
         @(posedge clk);
         cycles++;
      end
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state and idle immunity
      chk_state("R1 reset", 0, 0, 0);
      send(8'h00); send(8'hFF); send(8'h00); send(8'hFF);
      chk_state("R1 idle samples", 0, 0, 0);

      // R4 R5 sweep: every channel, mode, position
      for (int ch = 0; ch < CH_N; ch++) begin
         for (int md = 0; md < 4; md++) begin
            for (int p = 1; p <= 3; p++) begin
               int pre;
               pre = (md == 0) ? 0 : (md == 1) ? 1 : (p % 2);
               do_arm(ch, md, 0);
               for (int k = 0; k < p; k++) send(mk(ch, pre, k));
               chk("R5 no fire before edge", int'(trig_hit), 0);
               send(mk(ch, 1 - pre, p));
               chk("R4 edge fires", int'(trig_hit), 1);
               chk("R7 index", int'(trig_idx), p);
               chk("R7 cap_active", int'(cap_active), 1);
               if (md < 2 && p == 1) begin
                  do_arm(ch, md, 0);
                  send(mk(ch, 1 - pre, 0));
                  send(mk(ch, pre, 1));
                  send(mk(ch, pre, 0));
                  chk("R4 opposite edge ignored", int'(trig_hit), 0);
               end
            end
         end
      end

      // R3 first sample after arm only seeds (earlier level was low)
      do_arm(2, 0, 0);
      send(8'h00);
      send(8'h00);
      do_arm(2, 0, 0);
      send(8'h04);
      chk_state("R3 seed sample", 0, 0, 0);
      send(8'h04);
      chk_state("R3 steady high", 0, 0, 0);

      // R6 gaps in the strobe are skipped
      do_arm(0, 0, 0);
      send(8'h00);
      repeat (3) begin
         @(negedge clk);
         smp_data = 8'h01;
      end
      @(negedge clk);
      chk("R6 gap no fire", int'(trig_hit), 0);
      send(8'h00);
      chk("R6 after gap", int'(trig_hit), 0);
      send(8'h01);
      chk_state("R6 index counts valid samples", 1, 0, 2);

      // R2 configuration changes while armed are ignored
      do_arm(0, 0, 0);
      cfg_chan = 3'd1; cfg_edge = 2'd1; cfg_timeout = 6'd1;
      send(8'h02); send(8'h00); send(8'h02); send(8'h00);
      chk_state("R2 cfg change ignored", 0, 0, 0);
      send(8'h01);
      chk_state("R2 latched cfg fires", 1, 0, 4);

      // R10 outcome frozen
      send(8'h00); send(8'h01); send(8'h00);
      chk_state("R10 hold after trigger", 1, 0, 4);

      // R12 arm with a valid sample in the same cycle
      @(negedge clk);
      cfg_chan = 3'd0; cfg_edge = 2'd0; cfg_timeout = 6'd0;
      arm = 1'b1; smp_vld = 1'b1; smp_data = 8'h00;
      @(negedge clk);
      arm = 1'b0; smp_vld = 1'b0;
      chk_state("R12 rearm clears", 0, 0, 0);
      send(8'h01);
      chk("R12 arm sample discarded", int'(trig_hit), 0);
      send(8'h00); send(8'h01);
      chk_state("R12 index from next sample", 1, 0, 2);

      // R8 timeout boundary
      do_arm(0, 0, 5);
      for (int k = 0; k < 4; k++) send(8'h00);
      chk_state("R8 before limit", 0, 0, 0);
      send(8'h00);
      chk_state("R8 fallback at limit", 0, 1, 0);
      send(8'h00); send(8'h01);
      chk_state("R10 hold after fallback", 0, 1, 0);

      // R8 trigger on the last allowed sample wins
      do_arm(0, 0, 3);
      send(8'h00); send(8'h00); send(8'h01);
      chk_state("R8 trigger beats fallback", 1, 0, 2);

      // R9 and R11: wait forever, index saturates
      do_arm(0, 0, 0);
      for (int k = 0; k < 70; k++) send(8'h00);
      chk_state("R9 no fallback", 0, 0, 0);
      send(8'h01);
      chk_state("R11 saturated index", 1, 0, IDX_MAX);

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule